// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the front end of a processor's debug port. An external debug controller raises a request line. The block waits until the core reports that its current instruction has retired, then enters debug mode. It answers the controller with an acknowledge pulse on a serial data-out line. From then on it accepts 8-bit commands, which the controller shifts in on a serial data line under its own serial clock. The serial clock, data-in and request are brought into the system clock domain through flop synchronisers. The rising edges of the synchronised serial clock mark the bit times.

A counter tracks the bits of each command. When a byte is complete, a decoder splits it into a direction bit and a register-select field and fires a single read or write strobe. The request line has a second job: raising it while debug mode is already active resets the serial side. The partial byte is dropped and the acknowledge is sent again, so the controller can regain byte alignment. The core can also halt into debug mode by itself. A small status word records why debug mode was entered and holds two mode-select bits that commands can load.

The strobes are plain one-cycle pulses with no back-pressure. The core and the register file must take each strobe in the cycle it is shown. The serial side has no flow control either: every bit time the controller clocks in debug mode counts toward a command.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset, `dbg_mode`, `sdo`, `wake`, `rd_stb` and `wr_stb` are 0 and `dbg_status` is 0.
- R2: A synchronised high on `dbg_req` does not enter debug mode until `core_done` is seen. On `core_done`, `dbg_mode` rises and the cause field `dbg_status[1:0]` becomes 1 (request). The cause field changes only when debug mode is entered.
- R3: After debug mode is entered, `sdo` stays 0 until the first serial-clock rising edge. It is then 1 until the next serial-clock rising edge, and 0 afterwards. `sdo` is never 1 outside debug mode.
- R4: While `dbg_req` is still held after the acknowledge, serial bits are ignored: no strobe fires and no bit is kept toward the next command.
- R5: Once `dbg_req` is released, data-in is sampled at each serial-clock rising edge, MSB first. After 8 bits, exactly one one-cycle strobe fires: `rd_stb` if bit 7 is 1, `wr_stb` if bit 7 is 0. `reg_sel` carries bits 4:0. The two strobes are never high together, and they fire only from debug mode.
- R6: Raising `dbg_req` in debug mode discards any partial command and repeats the R3 acknowledge. The next 8 bits after release form a whole new command.
- R7: Each rising edge of the synchronised `dbg_req` gives exactly one one-cycle `wake` pulse.
- R8: A `core_halt` pulse outside debug mode enters debug mode and loads `core_cause` into `dbg_status[1:0]` (0 software, 2 breakpoint, 3 trace). It then sends the R3 acknowledge. If `dbg_req` is not held at the end of the acknowledge, command shifting starts directly.
- R9: A write command with select 31 loads command bits 6:5 into `dbg_status[3:2]`. The mode bits change on no other event.
- R10: A write command with select 30 leaves debug mode (`dbg_mode` falls). Its write strobe still fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debug request from the external controller (asynchronous) |
| core_done | input | 1 | Core has retired its current instruction (one-cycle pulse) |
| core_halt | input | 1 | Core halted into debug mode by itself (one-cycle pulse) |
| core_cause | input | 2 | Cause code that goes with `core_halt` |
| sclk | input | 1 | Serial clock from the controller (asynchronous) |
| sdi | input | 1 | Serial command data-in |
| sdo | output | 1 | Serial data-out carrying the acknowledge |
| dbg_mode | output | 1 | Debug mode active |
| wake | output | 1 | One-cycle wake pulse for a core in a low-power state |
| rd_stb | output | 1 | Read strobe for the selected register |
| wr_stb | output | 1 | Write strobe for the selected register |
| reg_sel | output | 5 | Register select of the last command |
| dbg_status | output | 4 | Mode bits [3:2] and entry cause [1:0] |

## Verification
Commands are shifted in with both directions and with select patterns of different shape: 0x05, 0x0A, 0x13 and 0x01. A swapped bit order, a wrong direction decode or a select field taken from the wrong bits would each give a wrong `reg_sel` or the wrong strobe. A full byte of ones is clocked in while the request is still held, and a three-bit partial command is cut off by a second request. Both are followed by a clean command. Any leftover bit would shift that command out of alignment and change its select, which separates a real counter clear from a missing one. The acknowledge level is sampled before, between and after the two serial-clock edges. Request entry and core-halt entry are both exercised, and they are told apart by their cause codes.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  typedef enum logic [2:0] {
    ST_RUN,    // normal execution
    ST_WAITC,  // request seen, waiting for the core to retire
    ST_ACK0,   // debug entered, waiting for first serial edge
    ST_ACK1,   // acknowledge level on data-out
    ST_HOLD,   // acknowledge sent, request still held
    ST_DBG     // shifting commands
  } dbg_state_e;

  localparam logic [1:0] CAUSE_SW    = 2'd0;
  localparam logic [1:0] CAUSE_REQ   = 2'd1;
  localparam logic [1:0] CAUSE_BKPT  = 2'd2;
  localparam logic [1:0] CAUSE_TRACE = 2'd3;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbg_shifter.sv
module dbg_shifter #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_stb,
  input  logic             bit_in,
  output logic             cmd_vld,
  output logic [CMD_W-1:0] cmd
);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] nxt;

  assign nxt = {cmd[CMD_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmd     <= '0;
      cmd_vld <= 1'b0;
    end else begin
      cmd_vld <= 1'b0;
      if (!en) begin
        cnt <= '0;                 // any partial command is dropped
      end else if (bit_stb) begin
        cmd <= nxt;
        if (cnt == LAST) begin
          cnt     <= '0;
          cmd_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_decoder.sv
module dbg_decoder #(
  parameter int CMD_W = 8,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [CMD_W-1:0] cmd,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [SEL_W-1:0] reg_sel,
  output logic             mode_wr,
  output logic             resume,
  output logic [CMD_W-2-SEL_W:0] mode_val
);
  localparam int DIR_BIT = CMD_W - 1;
  localparam logic [SEL_W-1:0] SEL_MODE   = '1;
  localparam logic [SEL_W-1:0] SEL_RESUME = SEL_MODE - 1'b1;

  logic             is_rd;
  logic [SEL_W-1:0] sel;

  assign is_rd    = cmd[DIR_BIT];
  assign sel      = cmd[SEL_W-1:0];
  assign mode_val = cmd[DIR_BIT-1:SEL_W];
  assign mode_wr  = cmd_vld && !is_rd && (sel == SEL_MODE);
  assign resume   = cmd_vld && !is_rd && (sel == SEL_RESUME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      reg_sel <= '0;
    end else begin
      rd_stb <= cmd_vld && is_rd;
      wr_stb <= cmd_vld && !is_rd;
      if (cmd_vld) reg_sel <= sel;
    end
  end
endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_port_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              srise,
  input  logic              core_done,
  input  logic              core_halt,
  input  logic [1:0]        core_cause,
  input  logic              mode_wr,
  input  logic              resume,
  input  logic [MODE_W-1:0] mode_val,
  output logic              dbg_mode,
  output logic              sdo,
  output logic              shift_en,
  output logic              wake,
  output logic [MODE_W+1:0] status
);
  dbg_state_e        st;
  logic              req_q;
  logic [1:0]        cause;
  logic [MODE_W-1:0] mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      req_q <= 1'b0;
      wake  <= 1'b0;
      cause <= CAUSE_SW;
      mode  <= '0;
    end else begin
      req_q <= req_s;
      wake  <= req_s && !req_q;
      unique case (st)
        ST_RUN: begin
          if (core_halt) begin
            cause <= core_cause;
            st    <= ST_ACK0;
          end else if (req_s) begin
            st <= ST_WAITC;
          end
        end
        ST_WAITC: if (core_done) begin
          cause <= CAUSE_REQ;
          st    <= ST_ACK0;
        end
        ST_ACK0: if (srise) st <= ST_ACK1;
        ST_ACK1: if (srise) st <= req_s ? ST_HOLD : ST_DBG;
        ST_HOLD: if (!req_s) st <= ST_DBG;
        ST_DBG: begin
          if (req_s)       st <= ST_ACK0;   // resynchronise
          else if (resume) st <= ST_RUN;
          if (mode_wr) mode <= mode_val;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign dbg_mode = (st == ST_ACK0) || (st == ST_ACK1) ||
                    (st == ST_HOLD) || (st == ST_DBG);
  assign sdo      = (st == ST_ACK1);
  assign shift_en = (st == ST_DBG) && !req_s;
  assign status   = {mode, cause};
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int CMD_W       = 8,
  parameter int SEL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_req,
  input  logic             core_done,
  input  logic             core_halt,
  input  logic [1:0]       core_cause,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             dbg_mode,
  output logic             wake,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [SEL_W-1:0] reg_sel,
  output logic [CMD_W-SEL_W:0] dbg_status
);
  localparam int MODE_W = CMD_W - 1 - SEL_W;

  logic [2:0]        sync_q;
  logic              req_s, sclk_s, sdi_s, sclk_q, srise;
  logic              shift_en, cmd_vld, mode_wr, resume;
  logic [CMD_W-1:0]  cmd;
  logic [MODE_W-1:0] mode_val;

  dbg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dbg_req, sclk, sdi}), .q(sync_q)
  );
  assign {req_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end
  assign srise = sclk_s && !sclk_q;

  dbg_shifter #(.CMD_W(CMD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .bit_stb(srise),
    .bit_in(sdi_s), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  dbg_decoder #(.CMD_W(CMD_W), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_sel(reg_sel),
    .mode_wr(mode_wr), .resume(resume), .mode_val(mode_val)
  );

  dbg_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .srise(srise),
    .core_done(core_done), .core_halt(core_halt), .core_cause(core_cause),
    .mode_wr(mode_wr), .resume(resume), .mode_val(mode_val),
    .dbg_mode(dbg_mode), .sdo(sdo), .shift_en(shift_en), .wake(wake),
    .status(dbg_status)
  );
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk #(
  parameter int SEL_W = 5,
  parameter int ST_W  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sdo,
  input logic            dbg_mode,
  input logic            wake,
  input logic            rd_stb,
  input logic            wr_stb,
  input logic [ST_W-1:0] dbg_status
);
  p_rw_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));

  p_strobe_from_debug_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> $past(dbg_mode));

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_ack_in_debug_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo |-> dbg_mode);

  p_cause_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_status[1:0] != $past(dbg_status[1:0])) |-> $rose(dbg_mode));

  p_mode_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_status[ST_W-1:2] != $past(dbg_status[ST_W-1:2])) |-> wr_stb);
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.SEL_W(SEL_W), .ST_W(CMD_W-SEL_W+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .dbg_mode(dbg_mode), .wake(wake),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .dbg_status(dbg_status)
);

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system cycles per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbg_req = 1'b0, core_done = 1'b0, core_halt = 1'b0;
  logic [1:0] core_cause = 2'd0;
  logic       sclk = 1'b0, sdi = 1'b0;
  logic       sdo, dbg_mode, wake, rd_stb, wr_stb;
  logic [4:0] reg_sel;
  logic [3:0] dbg_status;

  int total = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, wake_cnt = 0, ack_cnt = 0;
  int last_sel = -1;
  logic sdo_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .core_done(core_done),
    .core_halt(core_halt), .core_cause(core_cause), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .dbg_mode(dbg_mode), .wake(wake), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .reg_sel(reg_sel), .dbg_status(dbg_status)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rd_stb) begin rd_cnt++; last_sel = reg_sel; end
      if (wr_stb) begin wr_cnt++; last_sel = reg_sel; end
      if (wake) wake_cnt++;
      if (sdo && !sdo_q) ack_cnt++;
    end
    sdo_q <= sdo;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) sbit(c[i]);
    wait_clk(6);
  endtask

  task automatic t_reset;
    chk("R1 dbg_mode", dbg_mode, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 strobes", rd_stb | wr_stb | wake, 0);
    chk("R1 status", dbg_status, 0);
  endtask

  task automatic t_enter;
    dbg_req = 1'b1;
    wait_clk(8);
    chk("R2 no entry before core_done", dbg_mode, 0);
    chk("R7 wake count", wake_cnt, 1);
    core_done = 1'b1;
    wait_clk(1);
    core_done = 1'b0;
    wait_clk(3);
    chk("R2 dbg_mode", dbg_mode, 1);
    chk("R2 cause request", dbg_status[1:0], 1);
    chk("R3 sdo low before edge", sdo, 0);
    sbit(1'b0);
    chk("R3 sdo high after first edge", sdo, 1);
    sbit(1'b0);
    chk("R3 sdo low after second edge", sdo, 0);
    chk("R3 ack count", ack_cnt, 1);
  endtask

  task automatic t_hold_ignore;
    send_cmd(8'hFF);
    chk("R4 no strobe while held", rd_cnt + wr_cnt, 0);
    dbg_req = 1'b0;
    wait_clk(6);
    send_cmd(8'h85);
    chk("R4 R5 read count", rd_cnt, 1);
    chk("R4 R5 read select", last_sel, 5);
  endtask

  task automatic t_patterns;
    send_cmd(8'h0A);
    chk("R5 write count", wr_cnt, 1);
    chk("R5 write select", last_sel, 10);
    send_cmd(8'h93);
    chk("R5 read count 2", rd_cnt, 2);
    chk("R5 read select 19", last_sel, 19);
  endtask

  task automatic t_mode;
    send_cmd(8'h5F);
    chk("R9 mode bits", dbg_status[3:2], 2);
    chk("R9 cause kept", dbg_status[1:0], 1);
    chk("R9 write strobe", wr_cnt, 2);
  endtask

  task automatic t_resync;
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    dbg_req = 1'b1;
    wait_clk(6);
    chk("R7 wake count 2", wake_cnt, 2);
    chk("R6 no strobe from partial", rd_cnt + wr_cnt, 4);
    sbit(1'b0);
    chk("R6 re-ack high", sdo, 1);
    sbit(1'b0);
    chk("R6 re-ack low", sdo, 0);
    chk("R6 ack count", ack_cnt, 2);
    dbg_req = 1'b0;
    wait_clk(6);
    send_cmd(8'h81);
    chk("R6 aligned read count", rd_cnt, 3);
    chk("R6 aligned select", last_sel, 1);
  endtask

  task automatic t_resume;
    send_cmd(8'h1E);
    chk("R10 write strobe", wr_cnt, 3);
    chk("R10 select", last_sel, 30);
    chk("R10 left debug", dbg_mode, 0);
    chk("R10 mode kept", dbg_status[3:2], 2);
  endtask

  task automatic t_halt;
    core_cause = 2'd3;
    core_halt  = 1'b1;
    wait_clk(1);
    core_halt  = 1'b0;
    wait_clk(3);
    chk("R8 dbg_mode", dbg_mode, 1);
    chk("R8 cause trace", dbg_status[1:0], 3);
    sbit(1'b0);
    chk("R8 ack high", sdo, 1);
    sbit(1'b0);
    send_cmd(8'h82);
    chk("R8 direct shift read", rd_cnt, 4);
    chk("R8 select", last_sel, 2);
    chk("R7 no extra wake", wake_cnt, 2);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset;
    t_enter;
    t_hold_ignore;
    t_patterns;
    t_mode;
    t_resync;
    t_resume;
    t_halt;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule